// File: doc/BRIEF.md
# Transactional Read-Set Tracking Table

The table remembers which cache lines a running hardware transaction has read, so that the transaction can be abandoned when another agent writes one of them before commit. It stores only line tags and valid bits, never data. A load made inside a transaction either finds its line already present or claims a free way in the set picked by the line address. A remote invalidation snoop that names a tracked line raises a conflict abort. A load whose line cannot be recorded because its set is full raises an overflow abort, because the line could no longer be watched.

Control comes from three strobes: one starts a transaction, one commits it and one abandons it. Starting a transaction empties the table in a single cycle. Committing or abandoning ends the transaction and also empties the table. Each abort indication stays set until the next start, and a cause code tells the two kinds apart. The default organisation is 4 sets by 8 ways over a 32-bit physical address with 64-byte lines. Address bits [7:6] select the set and bits [31:8] form the stored tag.

Top module: `rs_track_table`

## Requirements
- R1: A cycle with `tx_begin_i` high starts a transaction. One cycle later both abort outputs are 0 and `abort_cause_o` is 00, and every line tracked before that cycle is forgotten, so a later snoop to such a line has no effect.
- R2: Inside a live transaction, a load to an untracked line records it in set `addr[7:6]` with tag `addr[31:8]`. Address bits [5:0] are ignored, so any offset within a tracked line refers to that same line.
- R3: Inside a live transaction, a snoop to any byte of a tracked line sets `conflict_abort_o` one cycle later, with `abort_cause_o` = 01.
- R4: A snoop to a line that is not tracked has no effect. This includes a line with a matching tag but a different set.
- R5: Each set holds 8 distinct lines. A load to a 9th distinct line in a full set sets `overflow_abort_o` one cycle later, with `abort_cause_o` = 10. Lines placed in other sets do not use up that set's ways.
- R6: A load to a line that is already tracked uses no new way. Repeated loads to the same 8 lines of one set never cause an overflow.
- R7: When a snoop and a load to the same line arrive in the same cycle, the result is a conflict abort (cause 01) and never an overflow. This holds even when the line is untracked or its set is full.
- R8: Abort outputs are sticky until the next start. Only the first cause is kept: later snoops or loads, commit and abandon leave the outputs unchanged.
- R9: Commit (`tx_commit_i`) and abandon (`tx_abort_i`) end the transaction. After either one, loads and snoops have no effect until the next start.
- R10: Loads and snoops presented while no transaction is active are ignored. They allocate nothing and raise no abort.
- R11: After reset no transaction is active, both abort outputs are 0 and `abort_cause_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_begin_i | input | 1 | Start a transaction; clears table and abort state |
| tx_commit_i | input | 1 | Commit; ends the transaction and clears the table |
| tx_abort_i | input | 1 | Abandon; ends the transaction and clears the table |
| ld_valid_i | input | 1 | Transactional load strobe |
| ld_addr_i | input | 32 | Physical address of the load |
| snp_valid_i | input | 1 | Remote invalidation snoop strobe |
| snp_addr_i | input | 32 | Physical address of the snoop |
| conflict_abort_o | output | 1 | Sticky: a tracked line was invalidated |
| overflow_abort_o | output | 1 | Sticky: a line could not be tracked |
| abort_cause_o | output | 2 | 00 none, 01 conflict, 10 overflow |

## Verification
Two situations are the hardest to reach from the ports. The first is a full set receiving a new line in the same cycle as a snoop to that very line. Reaching it needs eight distinct fills of one set, then a single cycle that drives both strobes with matching line addresses but different offsets. The second is the case where ways can leak through hits or through fills of neighbouring sets. The sweep covers it by filling every set and then reloading each line at new offsets. It then fills the other sets, and only after that adds the ninth line. For every set and every way, the sweep then snoops that one way alone, which shows each stored tag is compared.

// File: rtl/rs_track_pkg.sv
package rs_track_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_OVERFLOW = 2'd2
  } abort_cause_e;
endpackage

// File: rtl/rs_way_match.sv
module rs_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 24
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [WAYS-1:0]       hit_vec_o,
  output logic                  hit_o,
  output logic                  full_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end
  assign hit_o  = |hit_vec_o;
  assign full_o = &valid_i;
endmodule

// File: rtl/rs_first_free.sv
module rs_first_free #(
  parameter int N = 8
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign gnt_o[i]    = free_i[i] && !seen[i];
    assign seen[i+1]   = seen[i] || free_i[i];
  end
endmodule

// File: rtl/rs_track_table.sv
module rs_track_table
  import rs_track_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 4,
  parameter int WAYS       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              tx_abort_i,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              conflict_abort_o,
  output logic              overflow_abort_o,
  output logic [1:0]        abort_cause_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  logic                    active_q;
  abort_cause_e            cause_q;
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]        tag_q [SETS][WAYS];

  logic [IDX_W-1:0] ld_idx, snp_idx;
  logic [TAG_W-1:0] ld_tag, snp_tag;
  assign ld_idx  = ld_addr_i[OFF_W +: IDX_W];
  assign snp_idx = snp_addr_i[OFF_W +: IDX_W];
  assign ld_tag  = ld_addr_i[ADDR_W-1 -: TAG_W];
  assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  logic [WAYS*TAG_W-1:0] ld_row_tags, snp_row_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      ld_row_tags[w*TAG_W +: TAG_W]  = tag_q[ld_idx][w];
      snp_row_tags[w*TAG_W +: TAG_W] = tag_q[snp_idx][w];
    end
  end

  logic [WAYS-1:0] ld_hit_vec, snp_hit_vec, ld_gnt;
  logic            ld_hit, ld_full, snp_hit, snp_full_unused;

  rs_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_ld_match (
    .valid_i   (valid_q[ld_idx]),
    .tags_i    (ld_row_tags),
    .tag_i     (ld_tag),
    .hit_vec_o (ld_hit_vec),
    .hit_o     (ld_hit),
    .full_o    (ld_full)
  );

  rs_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_snp_match (
    .valid_i   (valid_q[snp_idx]),
    .tags_i    (snp_row_tags),
    .tag_i     (snp_tag),
    .hit_vec_o (snp_hit_vec),
    .hit_o     (snp_hit),
    .full_o    (snp_full_unused)
  );

  rs_first_free #(.N(WAYS)) i_pick (
    .free_i (~valid_q[ld_idx]),
    .gnt_o  (ld_gnt)
  );

  // transaction live and not yet doomed
  logic live, same_line, snp_conflict, ld_miss, ld_overflow, ld_alloc;
  assign live         = active_q && (cause_q == CAUSE_NONE);
  assign same_line    = ld_valid_i && (ld_addr_i[ADDR_W-1:OFF_W] == snp_addr_i[ADDR_W-1:OFF_W]);
  assign snp_conflict = live && snp_valid_i && (snp_hit || same_line);
  assign ld_miss      = live && ld_valid_i && !ld_hit;
  assign ld_overflow  = ld_miss && ld_full && !snp_conflict;
  assign ld_alloc     = ld_miss && !ld_full && !snp_conflict;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cause_q  <= CAUSE_NONE;
      valid_q  <= '0;
    end else if (tx_begin_i) begin
      active_q <= 1'b1;
      cause_q  <= CAUSE_NONE;
      valid_q  <= '0;
    end else if (tx_commit_i || tx_abort_i) begin
      active_q <= 1'b0;
      valid_q  <= '0;
    end else if (snp_conflict) begin
      cause_q <= CAUSE_CONFLICT;
    end else if (ld_overflow) begin
      cause_q <= CAUSE_OVERFLOW;
    end else if (ld_alloc) begin
      valid_q[ld_idx] <= valid_q[ld_idx] | ld_gnt;
    end
  end

  // tag payload needs no reset: valid bits qualify it
  always_ff @(posedge clk_i) begin
    if (ld_alloc && !tx_begin_i && !tx_commit_i && !tx_abort_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ld_gnt[w]) tag_q[ld_idx][w] <= ld_tag;
      end
    end
  end

  assign conflict_abort_o = (cause_q == CAUSE_CONFLICT);
  assign overflow_abort_o = (cause_q == CAUSE_OVERFLOW);
  assign abort_cause_o    = cause_q;
endmodule

// File: rtl/rs_track_chk.sv
module rs_track_chk #(
  parameter int WAYS = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_begin_i,
  input logic            ld_valid_i,
  input logic            snp_valid_i,
  input logic            conflict_abort_o,
  input logic            overflow_abort_o,
  input logic [1:0]      abort_cause_o,
  input logic            active_q,
  input logic [WAYS-1:0] ld_hit_vec,
  input logic [WAYS-1:0] snp_hit_vec
);
  // R1
  begin_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_begin_i |=> (abort_cause_o == 2'd0));
  // R8
  sticky_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_abort_o && !tx_begin_i |=> conflict_abort_o);
  // R8
  sticky_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_abort_o && !tx_begin_i |=> overflow_abort_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q && !tx_begin_i |=> $stable(abort_cause_o));
  // R3
  conflict_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conflict_abort_o) |-> $past(snp_valid_i));
  // R5
  overflow_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_abort_o) |-> $past(ld_valid_i));
  // R6
  unique_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_hit_vec) && $onehot0(snp_hit_vec));
endmodule

bind rs_track_table rs_track_chk #(.WAYS(WAYS)) i_rs_track_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .tx_begin_i       (tx_begin_i),
  .ld_valid_i       (ld_valid_i),
  .snp_valid_i      (snp_valid_i),
  .conflict_abort_o (conflict_abort_o),
  .overflow_abort_o (overflow_abort_o),
  .abort_cause_o    (abort_cause_o),
  .active_q         (active_q),
  .ld_hit_vec       (ld_hit_vec),
  .snp_hit_vec      (snp_hit_vec)
);

// File: tb/test_rs_track_table.sv
module test_rs_track_table;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_begin_i = 1'b0, tx_commit_i = 1'b0, tx_abort_i = 1'b0;
  logic        ld_valid_i = 1'b0, snp_valid_i = 1'b0;
  logic [31:0] ld_addr_i = '0, snp_addr_i = '0;
  logic        conflict_abort_o, overflow_abort_o;
  logic [1:0]  abort_cause_o;

  int n_chk = 0, n_fail = 0;

  always #5ns clk_i = ~clk_i;

  rs_track_table i_rs_track_table (
    .clk_i, .rst_ni, .tx_begin_i, .tx_commit_i, .tx_abort_i,
    .ld_valid_i, .ld_addr_i, .snp_valid_i, .snp_addr_i,
    .conflict_abort_o, .overflow_abort_o, .abort_cause_o
  );

  function automatic logic [31:0] mk(int tag, int set, int off);
    logic [23:0] t = tag[23:0];
    logic [1:0]  s = set[1:0];
    logic [5:0]  o = off[5:0];
    return {t, s, o};
  endfunction

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask
  task automatic do_begin();  tx_begin_i = 1; cyc(); tx_begin_i = 0; endtask
  task automatic do_commit(); tx_commit_i = 1; cyc(); tx_commit_i = 0; endtask
  task automatic do_abort();  tx_abort_i = 1; cyc(); tx_abort_i = 0; endtask
  task automatic load(logic [31:0] a);
    ld_valid_i = 1; ld_addr_i = a; cyc(); ld_valid_i = 0;
  endtask
  task automatic snoop(logic [31:0] a);
    snp_valid_i = 1; snp_addr_i = a; cyc(); snp_valid_i = 0;
  endtask
  task automatic both(logic [31:0] l, logic [31:0] s);
    ld_valid_i = 1; ld_addr_i = l; snp_valid_i = 1; snp_addr_i = s;
    cyc(); ld_valid_i = 0; snp_valid_i = 0;
  endtask

  // expected cause: 0 none, 1 conflict, 2 overflow
  task automatic check(string req, int exp);
    logic [3:0] got, want;
    got  = {conflict_abort_o, overflow_abort_o, abort_cause_o};
    want = {exp == 1, exp == 2, exp[1:0]};
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got conf/ovf/cause=%b expected %b", req, got, want);
    end
  endtask

  initial begin
    #2ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R11 reset", 0);

    // R10: no transaction active
    for (int t = 0; t < 9; t++) load(mk(t + 1, 0, 0));
    snoop(mk(1, 0, 0));
    check("R10 idle load/snoop", 0);

    // R2/R3/R4: every set, every way snooped alone
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 8; k++) begin
        do_begin();
        if (k == 0) check("R1 begin clears", 0);
        for (int w = 0; w < 8; w++) load(mk(16 * s + w + 1, s, (w * 5) % 64));
        check("R2 fill no abort", 0);
        snoop(mk(200, s, 0));
        snoop(mk(16 * s + k + 1, (s + 1) % 4, 0));
        check("R4 untracked snoop", 0);
        snoop(mk(16 * s + k + 1, s, 63));
        check("R3 tracked snoop", 1);
        do_abort();
      end
    end

    // R5/R6: hits and other sets do not consume ways
    for (int s = 0; s < 4; s++) begin
      do_begin();
      for (int w = 0; w < 8; w++) load(mk(300 + w, s, 0));
      for (int w = 0; w < 8; w++) load(mk(300 + w, s, 7 + w));
      for (int w = 0; w < 8; w++) load(mk(400 + w, (s + 1) % 4, 0));
      check("R6 hits no overflow", 0);
      load(mk(500, s, 3));
      check("R5 ninth line", 2);
      do_commit();
      check("R8 survives commit", 2);
      snoop(mk(300, s, 0));
      check("R8 kept after commit", 2);
    end

    // R7: same-cycle snoop and load
    do_begin();
    for (int w = 0; w < 8; w++) load(mk(600 + w, 2, 0));
    both(mk(700, 2, 0), mk(700, 2, 40));
    check("R7 full set same line", 1);
    do_begin();
    both(mk(701, 1, 0), mk(701, 1, 9));
    check("R7 untracked same line", 1);

    // R8: first cause kept
    do_begin();
    load(mk(800, 0, 0));
    snoop(mk(800, 0, 1));
    check("R8 conflict set", 1);
    for (int w = 0; w < 9; w++) load(mk(810 + w, 3, 0));
    check("R8 conflict kept over overflow", 1);
    do_abort();
    check("R8 survives abandon", 1);
    do_begin();
    check("R1 begin clears abort", 0);
    for (int w = 0; w < 9; w++) load(mk(820 + w, 1, 0));
    snoop(mk(820, 1, 0));
    check("R8 overflow kept over snoop", 2);

    // R1: begin forgets tracked lines
    do_begin();
    load(mk(900, 2, 0));
    do_begin();
    snoop(mk(900, 2, 0));
    check("R1 table cleared", 0);

    // R9: commit / abandon end the transaction
    load(mk(901, 3, 0));
    do_commit();
    snoop(mk(901, 3, 0));
    for (int w = 0; w < 9; w++) load(mk(910 + w, 3, 0));
    check("R9 after commit", 0);
    do_begin();
    load(mk(920, 0, 0));
    do_abort();
    snoop(mk(920, 0, 0));
    check("R9 after abandon", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule